// File: doc/BRIEF.md
# Configurable Omega-Flip Permutation Network

This block reorders the bits of a W-bit word by passing it through a fixed count of stages, one stage per clock cycle. There are two kinds of stage. An omega stage interleaves the lower and upper halves of the word into adjacent pairs. A flip stage does the opposite and splits adjacent pairs back into the two halves. Every stage also has its own W/2-bit control word, with one bit for each pair. A set bit exchanges the two bits of that pair after the mapping.

A select word, one bit per stage, picks the kind of each stage at run time. The stages are applied most significant select bit first. A mode input runs the exact inverse: it walks the slots from last to first, uses the opposite stage kind in each slot, and keeps the control word that belongs to that slot. A word permuted in the forward mode is therefore recovered by running it again in the inverse mode with the same select and control inputs. The control words are supplied from outside. A start pulse captures all inputs. The block stays busy while the stages run, then pulses done and holds the result.

Top module: `omega_flip_perm`

## Requirements
- R1: After reset, busy and done are 0 and dataOut is all zeros.
- R2: An omega stage with control c produces out[2i] = in[i] and out[2i+1] = in[i+W/2] when c[i] = 0, and the two swapped when c[i] = 1, for i in 0..W/2-1.
- R3: A flip stage with control c produces out[i] = in[2i] and out[i+W/2] = in[2i+1] when c[i] = 0, and the two swapped when c[i] = 1.
- R4: In the forward mode (decrypt = 0), stage k (k = 0 first) is a flip stage when stageSel[NSTAGE-1-k] is 1 and an omega stage when it is 0. Stage k uses ctrlWords[k*W/2 +: W/2]. The result is the output of the last stage.
- R5: In the inverse mode (decrypt = 1), step j uses slot k = NSTAGE-1-j with the opposite stage kind and the control word of slot k. For any data, select and control words, the inverse of the forward result gives back the original data.
- R6: A start seen while idle makes busy 1 from the next cycle. busy stays high for exactly NSTAGE cycles. done is then high for exactly one cycle, with busy low.
- R7: All inputs are captured in the cycle start is accepted. Changes to dataIn, stageSel, ctrlWords or decrypt, and any start pulse while busy, do not change the result or its timing.
- R8: Once done has pulsed, dataOut holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run; accepted only while idle |
| decrypt | input | 1 | 0 = forward permutation, 1 = inverse |
| dataIn | input | W | Word to permute |
| stageSel | input | NSTAGE | Stage kind per slot, MSB is slot 0; 1 = flip, 0 = omega |
| ctrlWords | input | NSTAGE*W/2 | Packed control words, slot k at bits k*W/2 upward |
| busy | output | 1 | High while stages run |
| done | output | 1 | One-cycle pulse when the last stage finishes |
| dataOut | output | W | Current word; the result after done |

## Verification
The bound checker covers the handshake on every cycle. It checks that busy rises after an accepted start, that a run lasts exactly NSTAGE busy cycles, that a start arriving mid-run is ignored, that done is a lone pulse with busy low, and that the output stays still while the block is idle. It cannot judge bit placement. The bench's scenarios are the only source of evidence for the omega and flip mappings, the per-slot select and control ordering, and the exact inverse. They do this through sweeps that compare against an arithmetic model: all-omega and all-flip runs, every select value, and forward-then-inverse round trips on random words.

// File: rtl/ofn_pkg.sv
package ofn_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } ofnStrobes_t;
endpackage

// File: rtl/ofn_stage.sv
module ofn_stage #(
  parameter int W = 8
) (
  input  logic [W-1:0]   dIn,
  input  logic           isFlip,
  input  logic [W/2-1:0] ctrl,
  output logic [W-1:0]   dOut
);
  localparam int H = W / 2;

  logic [W-1:0] omegaOut;
  logic [W-1:0] flipOut;

  for (genvar i = 0; i < H; i++) begin : gPair
    assign omegaOut[2*i]   = ctrl[i] ? dIn[i+H] : dIn[i];
    assign omegaOut[2*i+1] = ctrl[i] ? dIn[i]   : dIn[i+H];
    assign flipOut[i]      = ctrl[i] ? dIn[2*i+1] : dIn[2*i];
    assign flipOut[i+H]    = ctrl[i] ? dIn[2*i]   : dIn[2*i+1];
  end

  assign dOut = isFlip ? flipOut : omegaOut;
endmodule

// File: rtl/ofn_datapath.sv
module ofn_datapath
  import ofn_pkg::*;
#(
  parameter int W      = 8,
  parameter int NSTAGE = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ofnStrobes_t               strobes,
  input  logic [$clog2(NSTAGE)-1:0] stepIdx,
  input  logic                      decrypt,
  input  logic [W-1:0]              dataIn,
  input  logic [NSTAGE-1:0]         stageSel,
  input  logic [NSTAGE*(W/2)-1:0]   ctrlWords,
  output logic [W-1:0]              dataOut
);
  localparam int H     = W / 2;
  localparam int IDXW  = $clog2(NSTAGE);
  localparam int CTRLW = NSTAGE * H;
  localparam logic [IDXW-1:0] LASTIDX = IDXW'(NSTAGE - 1);

  logic [W-1:0]      dataReg;
  logic              modeReg;
  logic [NSTAGE-1:0] selReg;
  logic [CTRLW-1:0]  ctrlReg;

  logic [IDXW-1:0] slot;
  logic            slotFlip;
  logic [H-1:0]    slotCtrl;
  logic [W-1:0]    stageOut;

  always_comb begin
    slot     = modeReg ? (LASTIDX - stepIdx) : stepIdx;
    slotFlip = selReg[LASTIDX - slot] ^ modeReg;
    slotCtrl = ctrlReg[int'(slot)*H +: H];
  end

  ofn_stage #(.W(W)) uStage (
    .dIn    (dataReg),
    .isFlip (slotFlip),
    .ctrl   (slotCtrl),
    .dOut   (stageOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      modeReg <= 1'b0;
      selReg  <= '0;
      ctrlReg <= '0;
    end else if (strobes.load) begin
      dataReg <= dataIn;
      modeReg <= decrypt;
      selReg  <= stageSel;
      ctrlReg <= ctrlWords;
    end else if (strobes.step) begin
      dataReg <= stageOut;
    end
  end

  assign dataOut = dataReg;
endmodule

// File: rtl/ofn_control.sv
module ofn_control
  import ofn_pkg::*;
#(
  parameter int NSTAGE = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  output ofnStrobes_t               strobes,
  output logic [$clog2(NSTAGE)-1:0] stepIdx,
  output logic                      busy,
  output logic                      done
);
  localparam int IDXW = $clog2(NSTAGE);
  localparam logic [IDXW-1:0] LASTIDX = IDXW'(NSTAGE - 1);

  logic [IDXW-1:0] cnt;
  logic            running;

  always_comb begin
    strobes.load = start && !running;
    strobes.step = running;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      cnt     <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strobes.load) begin
        running <= 1'b1;
        cnt     <= '0;
      end else if (running) begin
        if (cnt == LASTIDX) begin
          running <= 1'b0;
          done    <= 1'b1;
          cnt     <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign stepIdx = cnt;
  assign busy    = running;
endmodule

// File: rtl/omega_flip_perm.sv
module omega_flip_perm
  import ofn_pkg::*;
#(
  parameter int W      = 8,
  parameter int NSTAGE = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    decrypt,
  input  logic [W-1:0]            dataIn,
  input  logic [NSTAGE-1:0]       stageSel,
  input  logic [NSTAGE*(W/2)-1:0] ctrlWords,
  output logic                    busy,
  output logic                    done,
  output logic [W-1:0]            dataOut
);
  localparam int IDXW = $clog2(NSTAGE);

  ofnStrobes_t     strobes;
  logic [IDXW-1:0] stepIdx;

  ofn_control #(.NSTAGE(NSTAGE)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobes (strobes),
    .stepIdx (stepIdx),
    .busy    (busy),
    .done    (done)
  );

  ofn_datapath #(.W(W), .NSTAGE(NSTAGE)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .stepIdx   (stepIdx),
    .decrypt   (decrypt),
    .dataIn    (dataIn),
    .stageSel  (stageSel),
    .ctrlWords (ctrlWords),
    .dataOut   (dataOut)
  );
endmodule

// File: rtl/ofn_checker.sv
module ofn_checker #(
  parameter int W      = 8,
  parameter int NSTAGE = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] dataOut
);
  localparam int CW = $clog2(NSTAGE + 1) + 1;

  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runCnt <= '0;
    else if (busy) runCnt <= runCnt + 1'b1;
    else runCnt <= '0;
  end

  AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy); // R6
  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (runCnt < CW'(NSTAGE))); // R7
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (runCnt == CW'(NSTAGE))); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(dataOut)); // R8
endmodule

bind omega_flip_perm ofn_checker #(.W(W), .NSTAGE(NSTAGE)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .dataOut (dataOut)
);

// File: tb/omega_flip_perm_test.sv
module omega_flip_perm_test;
  localparam int W      = 8;
  localparam int NSTAGE = 8;
  localparam int H      = W / 2;
  localparam int CTRLW  = NSTAGE * H;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic              decrypt = 1'b0;
  logic [W-1:0]      dataIn = '0;
  logic [NSTAGE-1:0] stageSel = '0;
  logic [CTRLW-1:0]  ctrlWords = '0;
  logic              busy, done;
  logic [W-1:0]      dataOut;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #2.5 clk = ~clk;

  omega_flip_perm #(.W(W), .NSTAGE(NSTAGE)) uut (
    .clk(clk), .rstN(rstN), .start(start), .decrypt(decrypt),
    .dataIn(dataIn), .stageSel(stageSel), .ctrlWords(ctrlWords),
    .busy(busy), .done(done), .dataOut(dataOut)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nFails = nFails + 1;
      nChecks = nChecks + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  task automatic checkVal(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkInt(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One stage by index arithmetic: omega (R2) or flip (R3)
  function automatic logic [W-1:0] stageRef(input logic [W-1:0] x, input logic isFlip,
                                            input logic [H-1:0] c);
    logic [W-1:0] y;
    for (int p = 0; p < W; p++) begin
      int src;
      if (!isFlip) begin
        int pr = p / 2;
        bit odd = (p % 2) == 1;
        if (c[pr]) src = odd ? pr : pr + H;
        else       src = odd ? pr + H : pr;
      end else begin
        int pr = p % H;
        bit up = p >= H;
        if (c[pr]) src = up ? 2 * pr : 2 * pr + 1;
        else       src = up ? 2 * pr + 1 : 2 * pr;
      end
      y[p] = x[src];
    end
    return y;
  endfunction

  function automatic logic [W-1:0] fwdRef(input logic [W-1:0] x, input logic [NSTAGE-1:0] sel,
                                          input logic [CTRLW-1:0] cw);
    logic [W-1:0] v = x;
    for (int k = 0; k < NSTAGE; k++)
      v = stageRef(v, sel[NSTAGE-1-k], cw[k*H +: H]);
    return v;
  endfunction

  function automatic logic [W-1:0] invRef(input logic [W-1:0] x, input logic [NSTAGE-1:0] sel,
                                          input logic [CTRLW-1:0] cw);
    logic [W-1:0] v = x;
    for (int j = 0; j < NSTAGE; j++) begin
      int k = NSTAGE - 1 - j;
      v = stageRef(v, !sel[NSTAGE-1-k], cw[k*H +: H]);
    end
    return v;
  endfunction

  function automatic logic [CTRLW-1:0] randCtrl();
    logic [CTRLW-1:0] v;
    for (int b = 0; b < CTRLW; b += 32) v[b +: 32] = $urandom;
    return v;
  endfunction

  // Runs one operation; disturb=1 changes inputs and pulses start mid-run (R7)
  task automatic runOp(input logic [W-1:0] d, input logic [NSTAGE-1:0] sel,
                       input logic [CTRLW-1:0] cw, input logic mode, input bit disturb,
                       output logic [W-1:0] res);
    int lat = 0;
    @(negedge clk);
    dataIn = d; stageSel = sel; ctrlWords = cw; decrypt = mode; start = 1'b1;
    while (1) begin
      @(negedge clk);
      lat++;
      start = 1'b0;
      if (disturb && lat == 3) begin
        dataIn = ~d; stageSel = ~sel; ctrlWords = ~cw; decrypt = ~mode; start = 1'b1;
      end
      if (done || lat > 4 * NSTAGE + 8) break;
    end
    res = dataOut;
    checkInt("R6 latency start to done", lat, NSTAGE + 1);
    dataIn = ~d; stageSel = ~sel; ctrlWords = ~cw; decrypt = ~mode; start = 1'b0;
    @(negedge clk);
    checkInt("R6 done single pulse", int'(done), 0);
    checkVal("R8 dataOut holds after done", dataOut, res);
  endtask

  initial begin
    logic [W-1:0] r, r2;
    repeat (3) @(negedge clk);
    // R1 reset values
    checkInt("R1 busy after reset", int'(busy), 0);
    checkInt("R1 done after reset", int'(done), 0);
    checkVal("R1 dataOut after reset", dataOut, '0);
    rstN = 1'b1;

    // R2: all-omega runs
    for (int n = 0; n < 64; n++) begin
      logic [W-1:0] d = W'($urandom);
      logic [CTRLW-1:0] cw = randCtrl();
      runOp(d, '0, cw, 1'b0, 0, r);
      checkVal("R2 all omega stages", r, fwdRef(d, '0, cw));
    end
    // R3: all-flip runs
    for (int n = 0; n < 64; n++) begin
      logic [W-1:0] d = W'($urandom);
      logic [CTRLW-1:0] cw = randCtrl();
      runOp(d, '1, cw, 1'b0, 0, r);
      checkVal("R3 all flip stages", r, fwdRef(d, '1, cw));
    end
    // R4: every select value, one-hot and random data
    for (int s = 0; s < 256; s++) begin
      logic [W-1:0] d = (s % 3 == 0) ? W'(1) << (s % W) : W'($urandom);
      logic [CTRLW-1:0] cw = randCtrl();
      runOp(d, NSTAGE'(s), cw, 1'b0, 0, r);
      checkVal("R4 select sweep forward", r, fwdRef(d, NSTAGE'(s), cw));
    end
    // R5: inverse model and round trip
    for (int n = 0; n < 200; n++) begin
      logic [W-1:0] d = W'($urandom);
      logic [NSTAGE-1:0] s = NSTAGE'($urandom);
      logic [CTRLW-1:0] cw = randCtrl();
      runOp(d, s, cw, 1'b1, 0, r);
      checkVal("R5 inverse mode", r, invRef(d, s, cw));
      runOp(d, s, cw, 1'b0, 0, r);
      runOp(r, s, cw, 1'b1, 0, r2);
      checkVal("R5 round trip restores data", r2, d);
    end
    // R7: inputs and start disturbed mid-run
    for (int n = 0; n < 40; n++) begin
      logic [W-1:0] d = W'($urandom);
      logic [NSTAGE-1:0] s = NSTAGE'($urandom);
      logic [CTRLW-1:0] cw = randCtrl();
      logic m = n[0];
      runOp(d, s, cw, m, 1, r);
      checkVal("R7 mid-run changes ignored", r, m ? invRef(d, s, cw) : fwdRef(d, s, cw));
    end
    // R8: long idle hold
    repeat (10) @(negedge clk);
    checkVal("R8 dataOut holds over idle", dataOut, r);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule